// File: doc/BRIEF.md
# Gated-Clock Parallel/Serial-In Serial-Out Shift Register

This block is a shift register of parameterised width (eight stages by default). It takes a whole word from a parallel bus or one bit at a time from a serial input, and it presents the last stage on a serial output. That output can drive the serial input of a second instance, so instances chain into a longer register.

The register does not act on every system clock. It acts on the rising edge of a combined clock, which is the OR of a shift-clock input and a clock-inhibit input. In practice one input is the clock and the other is its enable. The active-low mode input chooses between two actions on each combined-clock edge: a synchronous load of the parallel word, or a shift by one place toward the output. An active-low clear acts at once and overrides every other input. A monitor output reports any rise of the inhibit input while the shift clock is low, because that rise would itself clock the register.

All inputs are sampled by a free-running system clock, `sys_clk`. A small state machine follows the combined clock with three states:
- `ST_ARMED`: combined clock low.
- `ST_RUN_HI`: shift clock high with inhibit low.
- `ST_HELD`: inhibit high.

The machine moves from `ST_ARMED` to `ST_RUN_HI` on a shift-clock rise, which fires the register. It moves from `ST_ARMED` to `ST_HELD` when inhibit rises, which fires the register and flags a fault if the shift clock is low. It moves from `ST_RUN_HI` to `ST_HELD` on a legal inhibit rise, and from `ST_RUN_HI` to `ST_ARMED` when the shift clock falls. From `ST_HELD` it returns to `ST_ARMED` or `ST_RUN_HI` when inhibit drops. Clear forces `ST_HELD`.

Top module: `gated_piso_shifter`

## Requirements
- R1: While `clear_n` is low, every stage is zero, `ser_out` is 0 and `inhibit_fault` is 0. This takes effect immediately, without waiting for a `sys_clk` edge.
- R2: The register changes only at a `sys_clk` edge where the combined clock (`shclk_in` OR `inhibit_in`) is 1 and was 0 at the previous edge. At all other edges the contents hold.
- R3: While `inhibit_in` stays high, toggling `shclk_in` changes nothing, whatever the value of `load_n`.
- R4: On a combined-clock rise with `load_n` = 0, stage i takes `par_in[i]`, and `ser_in` is ignored. On that same edge `ser_out` becomes `par_in[W-1]`.
- R5: On a combined-clock rise with `load_n` = 1, stage 0 takes `ser_in` and stage i takes stage i-1. `ser_out` is stage W-1, so a loaded word leaves the output highest bit first.
- R6: If `inhibit_in` is sampled high after having been sampled low, while `shclk_in` is sampled low, `inhibit_fault` is 1 for exactly the next `sys_clk` cycle. Such a rise also clocks the register.
- R7: After `clear_n` rises, the register is first clocked only by a combined-clock rise that begins after the release. A combined clock that is already high does not clock it.
- R8: With the `ser_out` of one instance wired to the `ser_in` of a second, the two behave as a single 2W-stage register on shift edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running sampling clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| shclk_in | input | 1 | Shift clock (one leg of the combined clock) |
| inhibit_in | input | 1 | Clock inhibit (other leg of the combined clock) |
| load_n | input | 1 | 0 = parallel load, 1 = shift, on a combined-clock rise |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | W | Parallel word, bit i to stage i |
| ser_out | output | 1 | Last stage |
| inhibit_fault | output | 1 | One-cycle pulse on an illegal inhibit rise |

## Verification
The bench loads distinct words (0xA5, 0x3C) and shifts them out with an alternating serial pattern and a constant one. These two patterns separate load order from shift order and show that `ser_in` is ignored during a load. Toggling the clock with inhibit held high, and in both modes, separates "held" from "loaded" and "shifted". A rise of inhibit with the shift clock low separates a legal inhibit from an illegal one, and the shift it causes is checked as well. A clear in the middle of a shift, and a cascade of two instances over 16 edges, separate the asynchronous clear and correct chaining from a register that is merely long enough.

// File: rtl/gps_pkg.sv
package gps_pkg;
    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_RUN_HI = 2'd1,
        ST_HELD   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/gps_edge_fsm.sv
module gps_edge_fsm
    import gps_pkg::*;
(
    input  logic        sys_clk,
    input  logic        clear_n,
    input  logic        shclk_in,
    input  logic        inhibit_in,
    output logic        fire_o,
    output logic        illegal_o,
    output logic        fault_o,
    output gate_state_e state_o
);
    gate_state_e state_q, state_d;

    // next state from the sampled pair
    always_comb begin
        if (inhibit_in)    state_d = ST_HELD;
        else if (shclk_in) state_d = ST_RUN_HI;
        else               state_d = ST_ARMED;
    end

    always_ff @(posedge sys_clk or negedge clear_n) begin
        if (!clear_n) state_q <= ST_HELD;
        else          state_q <= state_d;
    end

    // outputs per state
    always_comb begin
        fire_o    = 1'b0;
        illegal_o = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                fire_o    = shclk_in | inhibit_in;
                illegal_o = inhibit_in & ~shclk_in;
            end
            ST_RUN_HI: begin
                illegal_o = inhibit_in & ~shclk_in;
            end
            ST_HELD: begin
                fire_o    = 1'b0;
            end
            default: begin
                fire_o    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge sys_clk or negedge clear_n) begin
        if (!clear_n) fault_o <= 1'b0;
        else          fault_o <= illegal_o;
    end

    assign state_o = state_q;

    // R2: from the held state no edge can fire
    a_r2_held_no_fire: assert property (@(posedge sys_clk) disable iff (!clear_n)
        (state_q == ST_HELD) |-> !fire_o);

    // R6: a fault is only raised from a non-held state
    a_r6_fault_origin: assert property (@(posedge sys_clk) disable iff (!clear_n)
        illegal_o |-> (state_q != ST_HELD));
endmodule

// File: rtl/gps_stage_array.sv
module gps_stage_array #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         clear_n,
    input  logic         fire,
    input  logic         load_n,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] stage_o
);
    localparam int LAST = W - 1;

    logic [W-1:0] stage_q;
    logic [W-1:0] shift_src;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign shift_src[i] = ser_in;
            end else begin : g_body
                assign shift_src[i] = stage_q[i-1];
            end

            always_ff @(posedge sys_clk or negedge clear_n) begin
                if (!clear_n)   stage_q[i] <= 1'b0;
                else if (fire)  stage_q[i] <= load_n ? shift_src[i] : par_in[i];
            end
        end
    endgenerate

    assign stage_o = stage_q;

    // R4: load takes the whole word, serial input ignored
    a_r4_load_word: assert property (@(posedge sys_clk) disable iff (!clear_n)
        (fire && !load_n) |=> (stage_q == $past(par_in)));

    // R5: shift moves every bit one place toward the output
    a_r5_shift_step: assert property (@(posedge sys_clk) disable iff (!clear_n)
        (fire && load_n) |=> (stage_q[0] == $past(ser_in)) &&
                             (stage_q[LAST] == $past(stage_q[LAST-1])));

    // R2: no fire, no change
    a_r2_idle_hold: assert property (@(posedge sys_clk) disable iff (!clear_n)
        !fire |=> $stable(stage_q));
endmodule

// File: rtl/gated_piso_shifter.sv
module gated_piso_shifter
    import gps_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         clear_n,
    input  logic         shclk_in,
    input  logic         inhibit_in,
    input  logic         load_n,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic         ser_out,
    output logic         inhibit_fault
);
    logic        fire;
    logic        illegal;
    gate_state_e gstate;
    logic [W-1:0] stages;

    gps_edge_fsm u_fsm (
        .sys_clk    (sys_clk),
        .clear_n    (clear_n),
        .shclk_in   (shclk_in),
        .inhibit_in (inhibit_in),
        .fire_o     (fire),
        .illegal_o  (illegal),
        .fault_o    (inhibit_fault),
        .state_o    (gstate)
    );

    gps_stage_array #(.W(W)) u_stages (
        .sys_clk (sys_clk),
        .clear_n (clear_n),
        .fire    (fire),
        .load_n  (load_n),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .stage_o (stages)
    );

    assign ser_out = stages[W-1];

    // R1: clear holds everything at zero
    always_ff @(posedge sys_clk) begin
        if (!clear_n) begin
            a_r1_clear_zero: assert (stages == '0 && !inhibit_fault);
        end
    end

    // R3: inhibit held high keeps contents
    a_r3_inhibit_hold: assert property (@(posedge sys_clk) disable iff (!clear_n)
        (gstate == ST_HELD && inhibit_in) |=> $stable(stages));

    // R6: a fault pulse follows an inhibit rise with clock low
    a_r6_fault_cause: assert property (@(posedge sys_clk) disable iff (!clear_n)
        inhibit_fault |-> ($past(inhibit_in) && !$past(shclk_in)));
endmodule

// File: tb/sim_gated_piso_shifter.sv
module sim_gated_piso_shifter;
    localparam int W = 8;

    logic sys_clk = 1'b0;
    logic clear_n = 1'b0;
    logic shclk_in = 1'b0, inhibit_in = 1'b0, load_n = 1'b1, ser_in = 1'b0;
    logic [W-1:0] par0 = '0, par1 = '0;
    logic out0, out1, flt0, flt1;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit done = 0;

    always #2 sys_clk = ~sys_clk;

    gated_piso_shifter #(.W(W)) u0 (
        .sys_clk(sys_clk), .clear_n(clear_n), .shclk_in(shclk_in),
        .inhibit_in(inhibit_in), .load_n(load_n), .ser_in(ser_in),
        .par_in(par0), .ser_out(out0), .inhibit_fault(flt0));

    gated_piso_shifter #(.W(W)) u1 (
        .sys_clk(sys_clk), .clear_n(clear_n), .shclk_in(shclk_in),
        .inhibit_in(inhibit_in), .load_n(load_n), .ser_in(out0),
        .par_in(par1), .ser_out(out1), .inhibit_fault(flt1));

    // behavioural reference: queues, element 0 = entry stage
    bit q0[$], q1[$];
    bit pc, pi, mflt;

    task automatic mclear();
        q0.delete(); q1.delete();
        for (int k = 0; k < W; k++) begin q0.push_back(0); q1.push_back(0); end
        pc = 1; pi = 1; mflt = 0;
    endtask

    initial mclear();

    always @(negedge clear_n) mclear();

    always @(posedge sys_clk) begin
        if (clear_n) begin
            bit c, f, il, carry;
            c  = shclk_in | inhibit_in;
            f  = !pc && c;
            il = !pi && inhibit_in && !shclk_in;
            carry = q0[W-1];
            if (f) begin
                if (!load_n) begin
                    for (int k = 0; k < W; k++) begin q0[k] = par0[k]; q1[k] = par1[k]; end
                end else begin
                    void'(q0.pop_back()); q0.push_front(ser_in);
                    void'(q1.pop_back()); q1.push_front(carry);
                end
            end
            mflt = il; pc = c; pi = inhibit_in;
        end
    end

    task automatic check(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("u0 ser_out", out0, q0[W-1]);
        check("u1 ser_out", out1, q1[W-1]);
        check("u0 fault", flt0, mflt);
        check("u1 fault", flt1, mflt);
    endtask

    always @(posedge sys_clk) begin
        #1;
        if (!done) compare_all();
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic pulse();
        tick(); shclk_in = 1;
        tick(); shclk_in = 0;
    endtask

    initial begin : watchdog
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1"; tick(3);
        // R7: clock already high at release must not clock
        tag = "R7"; shclk_in = 1; load_n = 0; par0 = 8'hFF; par1 = 8'hFF;
        tick(); clear_n = 1; tick(3);
        shclk_in = 0; tick(2);
        // R4: load, serial ignored
        tag = "R4"; par0 = 8'hA5; par1 = 8'h3C; ser_in = 1; pulse();
        // R5: shift out with alternating serial
        tag = "R5"; load_n = 1;
        for (int k = 0; k < W; k++) begin ser_in = k[0]; pulse(); end
        // R3: load and shift while inhibited, raised legally with clock high
        tag = "R3"; tick(); shclk_in = 1; tick(); inhibit_in = 1; tick(); shclk_in = 0;
        load_n = 0; par0 = 8'h0F; par1 = 8'hF0; pulse(); pulse();
        load_n = 1; pulse();
        inhibit_in = 0; tick(2);
        tag = "R5"; ser_in = 1; for (int k = 0; k < 3; k++) pulse();
        // R6: illegal inhibit rise with clock low
        tag = "R6"; ser_in = 0; tick(); inhibit_in = 1; tick(3); inhibit_in = 0; tick(2);
        // R1: clear mid-shift, checked asynchronously
        tag = "R4"; load_n = 0; par0 = 8'hC3; par1 = 8'h81; pulse(); load_n = 1;
        tag = "R5"; pulse(); pulse();
        tag = "R1"; #1 clear_n = 0; #0.5;
        n_cmp++;
        if (out0 !== 1'b0 || out1 !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 async clear: actual %0b%0b expected 00", out0, out1);
        end
        tick(2); clear_n = 1; tick(2);
        // R8: cascade as one 16-stage register
        tag = "R8"; load_n = 0; par0 = 8'h96; par1 = 8'h5A; pulse(); load_n = 1;
        for (int k = 0; k < 2*W; k++) begin ser_in = (k % 3) == 0; pulse(); end
        tag = "R2"; tick(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule